// File: doc/BRIEF.md
# Exception Status and Cause Registers

This block keeps the processor-state and trap-cause registers of a system-control coprocessor for a small 32-bit core. The processor-state register (register number 12) holds a five-bit interrupt mask and a six-bit mode stack with three levels. Each level is a pair made of a privilege bit (0 = kernel, 1 = user) and an interrupt-enable bit (1 = allowed). The trap-cause register (register number 13) shows five pending-interrupt bits and the five-bit code of the last trap taken.

The pipeline pulses `take_exc` when it enters a trap handler and puts the trap code on `exc_code` in the same cycle. It pulses `ret_exc` when it returns from one. Software reaches both registers through a read/write port selected by register number. The read data is combinational from the stored state. The block samples five level-sensitive interrupt lines every cycle. It drives `irq_req` high when the current level has interrupts enabled and a pending line is unmasked.

The mode stack behaves as a four-state update machine, evaluated each cycle. The states are HOLD (no event; the stack keeps its value), LOAD (a software write to register 12), PUSH (`take_exc`; the stack shifts up one level and the current pair becomes 00) and POP (`ret_exc`; each lower pair takes the value of the pair above it). The transition into PUSH has priority over POP, and POP has priority over LOAD. HOLD is taken when no request is present.

Top module: `trap_csr_top`

## Requirements
- R1: After reset, register 12 and register 13 both read 0 and `irq_req` is 0. The core therefore starts in kernel mode with interrupts disabled.
- R2: A write to register 12 stores bits 12:8 as the mask and bits 5:0 as the stack. Bit 0 is the current enable, bit 1 the current privilege, bits 3:2 the previous pair and bits 5:4 the oldest pair. Every other bit of register 12 reads 0.
- R3: In the cycle after a `take_exc` pulse, stack bits 5:2 hold the former bits 3:0 and bits 1:0 are 00.
- R4: In the cycle after a `ret_exc` pulse without `take_exc`, stack bits 3:0 hold the former bits 5:2 and bits 5:4 are unchanged.
- R5: A `take_exc` pulse stores `exc_code` into register 13 bits 6:2. The code keeps its value in every other cycle.
- R6: Register 13 bits 12:8 show `irq_lines` as they were sampled at the previous clock edge.
- R7: `irq_req` is 1 exactly when stack bit 0 is 1 and the AND of the pending bits and the mask bits is nonzero.
- R8: Writes to register 13 have no effect. Its other bits read 0.
- R9: Reads of any register number other than 12 or 13 return 0. Writes to such a number change nothing.
- R10: When `take_exc` and `ret_exc` arrive in the same cycle, only the push is performed. When a trap event arrives in the same cycle as a write to register 12, the event decides the stack and the write still sets the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 5 | Level-sensitive interrupt requests, one per level |
| take_exc | input | 1 | One-cycle pulse: a trap is being taken |
| exc_code | input | 5 | Trap code, sampled when `take_exc` is high |
| ret_exc | input | 1 | One-cycle pulse: return from trap |
| reg_sel | input | 5 | Register number for read and write |
| reg_wr | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| irq_req | output | 1 | Combined interrupt request to the core |

## Verification
The stack is loaded with asymmetric patterns, so a push, a pop or a wrong shift direction gives a different readback. Push and pop are applied in sequence, so the bench can tell a pop that keeps the oldest pair from one that clears it. The interrupt output is tried three ways: with all levels masked, with only the pending level unmasked, and with the current enable cleared, which separates the mask path from the enable path. Same-cycle collisions of push with pop and of trap with software write are applied to confirm the priority order.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int STACK_W = 6;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_PUSH,
        OP_POP
    } stack_op_e;
endpackage

// File: rtl/trap_mode_stack.sv
module trap_mode_stack
    import trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic               load_i,
    input  logic [STACK_W-1:0] load_val_i,
    output logic [STACK_W-1:0] stack_o
);
    stack_op_e op;
    logic [STACK_W-1:0] stack_q;

    // request selection: push beats pop beats software load
    always_comb begin
        if (push_i)      op = OP_PUSH;
        else if (pop_i)  op = OP_POP;
        else if (load_i) op = OP_LOAD;
        else             op = OP_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stack_q <= '0;
        end else begin
            unique case (op)
                OP_HOLD: stack_q <= stack_q;
                OP_LOAD: stack_q <= load_val_i;
                OP_PUSH: stack_q <= {stack_q[STACK_W-3:0], 2'b00};
                OP_POP:  stack_q <= {stack_q[STACK_W-1:STACK_W-2], stack_q[STACK_W-1:2]};
                default: stack_q <= stack_q;
            endcase
        end
    end

    assign stack_o = stack_q;

    // R3: push moves the lower two pairs up and clears the current pair
    a_r3_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (stack_o[STACK_W-1:2] == $past(stack_o[STACK_W-3:0])) && (stack_o[1:0] == 2'b00));

    // R4: pop restores lower pairs and keeps the oldest pair
    a_r4_pop_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (stack_o[STACK_W-3:0] == $past(stack_o[STACK_W-1:2]))
                               && $stable(stack_o[STACK_W-1:STACK_W-2]));

    // R10: push wins over a same-cycle pop
    a_r10_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (stack_o[1:0] == 2'b00));
endmodule

// File: rtl/trap_irq_latch.sv
module trap_irq_latch #(
    parameter int LEVELS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] lines_i,
    input  logic              mask_we_i,
    input  logic [LEVELS-1:0] mask_val_i,
    input  logic              cur_ie_i,
    output logic [LEVELS-1:0] pend_o,
    output logic [LEVELS-1:0] mask_o,
    output logic              irq_o
);
    logic [LEVELS-1:0] hit;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        logic pend_q;
        logic mask_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                mask_q <= 1'b0;
            end else begin
                pend_q <= lines_i[lv];
                if (mask_we_i) mask_q <= mask_val_i[lv];
            end
        end

        assign pend_o[lv] = pend_q;
        assign mask_o[lv] = mask_q;
        assign hit[lv]    = pend_q & mask_q;
    end

    assign irq_o = cur_ie_i & (|hit);

    // R6: pending bits track the request lines one edge later
    a_r6_pend_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pend_o == $past(lines_i)));
endmodule

// File: rtl/trap_csr_top.sv
module trap_csr_top #(
    parameter int XLEN       = 32,
    parameter int LEVELS     = 5,
    parameter int CODE_W     = 5,
    parameter int SEL_W      = 5,
    parameter int STATUS_NUM = 12,
    parameter int CAUSE_NUM  = 13,
    parameter int MASK_LSB   = 8,
    parameter int PEND_LSB   = 8,
    parameter int CODE_LSB   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] irq_lines,
    input  logic              take_exc,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              ret_exc,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   rd_data,
    output logic              irq_req
);
    import trap_pkg::*;

    localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(STATUS_NUM);
    localparam logic [SEL_W-1:0] SEL_CAUSE  = SEL_W'(CAUSE_NUM);

    logic               status_we;
    logic [STACK_W-1:0] stack;
    logic [LEVELS-1:0]  pend;
    logic [LEVELS-1:0]  mask;
    logic [CODE_W-1:0]  code_q;
    logic               unused_wr_bits;

    assign status_we      = reg_wr && (reg_sel == SEL_STATUS);
    assign unused_wr_bits = ^{wr_data[XLEN-1:MASK_LSB+LEVELS], wr_data[MASK_LSB-1:STACK_W]};

    trap_mode_stack u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take_exc),
        .pop_i      (ret_exc),
        .load_i     (status_we),
        .load_val_i (wr_data[STACK_W-1:0]),
        .stack_o    (stack)
    );

    trap_irq_latch #(.LEVELS(LEVELS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines_i    (irq_lines),
        .mask_we_i  (status_we),
        .mask_val_i (wr_data[MASK_LSB +: LEVELS]),
        .cur_ie_i   (stack[0]),
        .pend_o     (pend),
        .mask_o     (mask),
        .irq_o      (irq_req)
    );

    // trap code: written only by the trap strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        code_q <= '0;
        else if (take_exc) code_q <= exc_code;
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel == SEL_STATUS) begin
            rd_data[MASK_LSB +: LEVELS] = mask;
            rd_data[STACK_W-1:0]        = stack;
        end else if (reg_sel == SEL_CAUSE) begin
            rd_data[PEND_LSB +: LEVELS] = pend;
            rd_data[CODE_LSB +: CODE_W] = code_q;
        end
    end

    // R5: code only moves on a trap
    a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take_exc |=> $stable(code_q));

    // R7: request needs the current enable
    a_r7_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> stack[0]);

    // R7: no unmasked pending level, no request
    a_r7_irq_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask) == '0) |-> !irq_req);

    // R9: unmapped numbers read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel != SEL_STATUS && reg_sel != SEL_CAUSE) |-> (rd_data == '0));
endmodule

// File: tb/sim_trap_csr_top.sv
`timescale 1ns/1ps
module sim_trap_csr_top;
    localparam real HALF = 2.5;
    localparam logic [4:0] ST = 5'd12;
    localparam logic [4:0] CA = 5'd13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_lines = '0;
    logic        take_exc = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        ret_exc = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0]  sel;
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } item_t;
    item_t q[$];

    always #(HALF) clk = ~clk;

    trap_csr_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .take_exc(take_exc),
        .exc_code(exc_code), .ret_exc(ret_exc), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req)
    );

    // driver: select a register and queue the expected result
    task automatic probe(input logic [4:0] sel, input logic [31:0] rd, input logic irq, input string tag);
        item_t it;
        @(negedge clk);
        reg_sel = sel;
        it.sel = sel; it.rd = rd; it.irq = irq; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic strobe(input logic tk, input logic rt, input logic [4:0] code,
                          input logic wr, input logic [4:0] sel, input logic [31:0] data);
        @(negedge clk);
        take_exc = tk; ret_exc = rt; exc_code = code;
        reg_wr = wr; reg_sel = sel; wr_data = data;
        @(negedge clk);
        take_exc = 1'b0; ret_exc = 1'b0; reg_wr = 1'b0; wr_data = '0;
    endtask

    task automatic set_lines(input logic [4:0] v);
        @(negedge clk);
        irq_lines = v;
    endtask

    // monitor: compares between edges
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (rd_data !== it.rd || irq_req !== it.irq) begin
                    errors++;
                    $display("FAIL %s sel=%0d rd=%h irq=%b expected rd=%h irq=%b",
                             it.tag, it.sel, rd_data, irq_req, it.rd, it.irq);
                end
            end
        end
    end

    initial begin
        #(HALF * 2 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        probe(ST, 32'h0, 1'b0, "R1 status");
        probe(CA, 32'h0, 1'b0, "R1 cause");

        strobe(0, 0, 0, 1, ST, 32'hFFFF_FFFF);
        probe(ST, 32'h0000_1F3F, 1'b0, "R2 field mask");

        strobe(0, 0, 0, 1, ST, 32'h0000_1F07);
        probe(ST, 32'h0000_1F07, 1'b0, "R2 load");
        strobe(1, 0, 5'h0D, 0, ST, 0);
        probe(ST, 32'h0000_1F1C, 1'b0, "R3 push");
        probe(CA, 32'h0000_0034, 1'b0, "R5 code");

        strobe(0, 1, 5'h11, 0, ST, 0);
        probe(ST, 32'h0000_1F17, 1'b0, "R4 pop");
        probe(CA, 32'h0000_0034, 1'b0, "R5 hold");

        set_lines(5'b00101);
        probe(CA, 32'h0000_0534, 1'b1, "R6 R7 pending");

        strobe(0, 0, 0, 1, ST, 32'h0000_0017);
        probe(ST, 32'h0000_0017, 1'b0, "R7 masked");
        strobe(0, 0, 0, 1, ST, 32'h0000_0417);
        probe(ST, 32'h0000_0417, 1'b1, "R7 unmasked");
        strobe(0, 0, 0, 1, ST, 32'h0000_0416);
        probe(ST, 32'h0000_0416, 1'b0, "R7 ie off");

        strobe(0, 0, 0, 1, CA, 32'hFFFF_FFFF);
        probe(CA, 32'h0000_0534, 1'b0, "R8 cause write");

        probe(5'd3, 32'h0, 1'b0, "R9 read");
        strobe(0, 0, 0, 1, 5'd3, 32'hFFFF_FFFF);
        probe(ST, 32'h0000_0416, 1'b0, "R9 write status");
        probe(CA, 32'h0000_0534, 1'b0, "R9 write cause");

        strobe(1, 1, 5'h1F, 0, ST, 0);
        probe(ST, 32'h0000_0418, 1'b0, "R10 push+pop");
        probe(CA, 32'h0000_057C, 1'b0, "R10 code");
        strobe(1, 0, 5'h02, 1, ST, 32'h0000_1F3F);
        probe(ST, 32'h0000_1F20, 1'b0, "R10 push+write");
        strobe(0, 1, 0, 0, ST, 0);
        probe(ST, 32'h0000_1F28, 1'b0, "R4 oldest kept");

        set_lines(5'b00000);
        probe(CA, 32'h0000_0008, 1'b0, "R6 cleared");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule